// File: doc/BRIEF.md
# EtherType Filter with PTP Receive Timestamp Capture

This block watches received Ethernet frames presented one byte per beat, with start-of-frame, end-of-frame and valid strobes. Bytes 12 and 13 form the EtherType. The block compares it against eight programmable filter words. The enabled filter with the lowest index whose EtherType matches is the winner. If that filter allows timestamping and the frame carries a PTP version 2 header whose message byte is the expected one, the block latches a free-running time value. On the same clock edge it latches the sender's clock identity and sequence number. A sticky valid flag then locks these capture registers until software clears the flag with a one-cycle pulse.

The block reports one cycle after the last byte of each frame. It gives the winning filter index, a packet-type word and a status word. Layer-3 and layer-4 classification, the RSS type and the RSS enable come in as side inputs, sampled on the end-of-frame beat. A simple write-only register port loads the filter words, the expected message byte and the global timestamp enable.

Top module: `rx_etype_stamp`

## Requirements
- R1: The filters are searched from index 0 upward. The first enabled filter whose EtherType equals frame bytes {12,13} (byte 12 is the high byte) wins, and its index is reported on `filt_idx_o`. The value 8 means no filter hit, which includes every frame shorter than 14 bytes. The search stops at the winner even when that filter takes no timestamp.
- R2: A filter word is written at register addresses 0 to 7. Bits 15:0 hold the EtherType, bit 26 enables the filter and bit 30 allows timestamping. All other bits of a filter word have no effect on matching, capture or metadata.
- R3: A capture needs all of the following: the winning filter's timestamp bit, the global enable (address 9, bit 0), a clear valid flag, and a frame of at least 46 bytes.
- R4: The frame also has to qualify on two header bytes. The low nibble of frame byte 15 (PTP header byte 1) must equal 2. Frame byte 14 (PTP header byte 0) must equal bits 15:8 of the configuration word at address 8.
- R5: A capture latches `timer_i` as sampled on the clock edge of the frame-byte-45 beat. The low half goes to `stamp_lo_o` and the high half to `stamp_hi_o`, and `ts_valid_o` is set. The flag stays set until `ts_clr_i` is pulsed, and while it is set no further capture happens.
- R6: A capture also loads two identity registers. `src_id_o` takes frame bytes 36..39 with byte 36 in bits 7:0. `src_seq_o` takes bytes 40..41 in bits 15:0 with byte 40 lowest, and bytes 44..45 in bits 31:16 with byte 44 lowest.
- R7: When a filter hit, `pkt_type_o` is the RSS type in bits 3:0 (zero if RSS is disabled), plus bit 11, plus the filter index in bits 6:4. The IP and L4 bits stay clear in this case.
- R8: When no filter hit, `pkt_type_o` is the RSS term plus three more terms. Bit 4 is set for IPv4 and bit 6 for IPv6. From `l4_kind_i` (1 TCP, 2 UDP, 3 SCTP, 0 none), exactly one of bit 8 (TCP), bit 9 (UDP) or bit 10 (SCTP) is set, or none of them.
- R9: Bit 16 of `stat_o` is set exactly when the frame just reported produced a capture. All other bits of `stat_o` are zero.
- R10: `done_o` rises on the clock edge that follows the end-of-frame beat and stays high for one cycle. `filt_idx_o`, `pkt_type_o` and `stat_o` are valid while it is high.
- R11: A frame that produces no capture leaves `stamp_lo_o`, `stamp_hi_o`, `src_id_o`, `src_seq_o` and `ts_valid_o` unchanged. This covers frames that are too short, frames with no hit and frames that fail qualification.
- R12: If `ts_clr_i` pulses on the same cycle as a capture, the capture wins and `ts_valid_o` stays set.
- R13: Reset clears every capture register, the valid flag and `done_o`. It also sets `filt_idx_o` to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address: 0-7 filters, 8 config, 9 control |
| reg_wdata_i | input | 32 | Register write data |
| ts_clr_i | input | 1 | Pulse that clears the valid flag |
| frm_vld_i | input | 1 | Byte beat valid |
| frm_sof_i | input | 1 | Beat carries the first byte of a frame |
| frm_eof_i | input | 1 | Beat carries the last byte of a frame |
| frm_data_i | input | 8 | Frame byte |
| timer_i | input | 64 | Free-running time value |
| rss_en_i | input | 1 | RSS enabled |
| rss_type_i | input | 4 | RSS type |
| is_ipv4_i | input | 1 | Frame classified as IPv4 |
| is_ipv6_i | input | 1 | Frame classified as IPv6 |
| l4_kind_i | input | 2 | L4 protocol: 0 none, 1 TCP, 2 UDP, 3 SCTP |
| ts_valid_o | output | 1 | Sticky capture valid flag |
| stamp_lo_o | output | 32 | Captured time, low half |
| stamp_hi_o | output | 32 | Captured time, high half |
| src_id_o | output | 32 | Captured 4-byte identity field |
| src_seq_o | output | 32 | Captured 2-byte identity field and sequence number |
| done_o | output | 1 | Per-frame metadata strobe |
| filt_idx_o | output | 4 | Winning filter index, 8 for none |
| pkt_type_o | output | 16 | Packet-type word |
| stat_o | output | 32 | Status word, bit 16 marks a capture |

## Verification
The capture registers and the valid flag change on the clock edge of the frame-byte-45 beat. The metadata and `done_o` change on the edge of the end-of-frame beat. All of them can therefore be read 1 ns after that edge. The bench drives each beat at the falling edge and checks every result 1 ns after the rising edge that closes the end-of-frame beat. One edge later it checks that `done_o` has fallen. The expected timestamp is the timer value the bench itself drove during the byte-45 beat. The timer advances only on rising edges, so that value is the one the design samples.

// File: rtl/rx_stamp_pkg.sv
package rx_stamp_pkg;
  localparam int POS_ET_HI = 12;
  localparam int POS_ET_LO = 13;
  localparam int POS_MSG   = 14;
  localparam int POS_VER   = 15;
  localparam int POS_ID0   = 36;
  localparam int ID_BYTES  = 6;
  localparam int POS_SEQ0  = 44;
  localparam int POS_LAST  = 45;

  localparam int FB_ETYPE_W = 16;
  localparam int FB_EN      = 26;
  localparam int FB_TS      = 30;

  localparam int PT_HIT  = 11;
  localparam int PT_IDX  = 4;
  localparam int PT_IPV4 = 4;
  localparam int PT_IPV6 = 6;
  localparam int PT_TCP  = 8;
  localparam int PT_UDP  = 9;
  localparam int PT_SCTP = 10;
  localparam int ST_TS   = 16;

  typedef enum logic [1:0] {
    L4_NONE = 2'd0,
    L4_TCP  = 2'd1,
    L4_UDP  = 2'd2,
    L4_SCTP = 2'd3
  } l4_kind_e;

  typedef struct packed {
    logic                  en;
    logic                  ts;
    logic [FB_ETYPE_W-1:0] etype;
  } filt_t;

  typedef struct packed {
    logic [7:0]            msg;
    logic [3:0]            ver;
    logic [8*ID_BYTES-1:0] id;
    logic [7:0]            seq_lo;
  } ptp_fld_t;
endpackage

// File: rtl/rx_stamp_regs.sv
module rx_stamp_regs
  import rx_stamp_pkg::*;
#(
  parameter int N_FILT = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output filt_t             filt_o [N_FILT],
  output logic [7:0]        msg_o,
  output logic              glob_en_o
);
  localparam logic [ADDR_W-1:0] CFG_ADDR  = ADDR_W'(N_FILT);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(N_FILT + 1);

  // queue, interrupt and reserved bits of filter words carry no function here
  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[31], wdata_i[29:27], wdata_i[25:16]};

  for (genvar g = 0; g < N_FILT; g++) begin : g_filt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        filt_o[g] <= '0;
      end else if (we_i && addr_i == ADDR_W'(g)) begin
        filt_o[g].en    <= wdata_i[FB_EN];
        filt_o[g].ts    <= wdata_i[FB_TS];
        filt_o[g].etype <= wdata_i[FB_ETYPE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_o     <= '0;
      glob_en_o <= 1'b0;
    end else if (we_i) begin
      if (addr_i == CFG_ADDR)  msg_o     <= wdata_i[15:8];
      if (addr_i == CTRL_ADDR) glob_en_o <= wdata_i[0];
    end
  end
endmodule

// File: rtl/rx_stamp_match.sv
module rx_stamp_match
  import rx_stamp_pkg::*;
#(
  parameter int N_FILT = 8,
  parameter int IDX_W  = 4
) (
  input  filt_t                 filt_i [N_FILT],
  input  logic [FB_ETYPE_W-1:0] etype_i,
  output logic                  hit_o,
  output logic [IDX_W-1:0]      idx_o,
  output logic                  ts_o
);
  logic [N_FILT-1:0] eq;

  for (genvar g = 0; g < N_FILT; g++) begin : g_cmp
    assign eq[g] = filt_i[g].en && (filt_i[g].etype == etype_i);
  end

  // walk downward so the lowest matching index is the last one assigned
  always_comb begin
    hit_o = 1'b0;
    idx_o = IDX_W'(N_FILT);
    ts_o  = 1'b0;
    for (int k = N_FILT - 1; k >= 0; k--) begin
      if (eq[k]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(k);
        ts_o  = filt_i[k].ts;
      end
    end
  end
endmodule

// File: rtl/rx_stamp_parse.sv
module rx_stamp_parse
  import rx_stamp_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  vld_i,
  input  logic                  sof_i,
  input  logic                  eof_i,
  input  logic [7:0]            data_i,
  output logic                  sof_beat_o,
  output logic                  eof_beat_o,
  output logic                  at_et_o,
  output logic                  at_last_o,
  output logic [FB_ETYPE_W-1:0] etype_o,
  output ptp_fld_t              fld_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, pos;
  logic [7:0]       et_hi_q;

  assign pos        = sof_i ? '0 : cnt_q;
  assign sof_beat_o = vld_i && sof_i;
  assign eof_beat_o = vld_i && eof_i;
  assign at_et_o    = vld_i && (pos == CNT_W'(POS_ET_LO));
  assign at_last_o  = vld_i && (pos == CNT_W'(POS_LAST));
  assign etype_o    = {et_hi_q, data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (vld_i) begin
      cnt_q <= (pos == CNT_MAX) ? CNT_MAX : pos + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      et_hi_q      <= '0;
      fld_o.msg    <= '0;
      fld_o.ver    <= '0;
      fld_o.seq_lo <= '0;
    end else if (vld_i) begin
      if (pos == CNT_W'(POS_ET_HI)) et_hi_q      <= data_i;
      if (pos == CNT_W'(POS_MSG))   fld_o.msg    <= data_i;
      if (pos == CNT_W'(POS_VER))   fld_o.ver    <= data_i[3:0];
      if (pos == CNT_W'(POS_SEQ0))  fld_o.seq_lo <= data_i;
    end
  end

  for (genvar g = 0; g < ID_BYTES; g++) begin : g_id
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fld_o.id[8*g +: 8] <= '0;
      end else if (vld_i && pos == CNT_W'(POS_ID0 + g)) begin
        fld_o.id[8*g +: 8] <= data_i;
      end
    end
  end
endmodule

// File: rtl/rx_etype_stamp.sv
module rx_etype_stamp
  import rx_stamp_pkg::*;
#(
  parameter int  N_FILT = 8,
  parameter int  TS_W   = 64,
  parameter int  CNT_W  = 6,
  localparam int IDX_W  = $clog2(N_FILT + 1),
  localparam int ADDR_W = $clog2(N_FILT + 2),
  localparam int HALF_W = TS_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              ts_clr_i,
  input  logic              frm_vld_i,
  input  logic              frm_sof_i,
  input  logic              frm_eof_i,
  input  logic [7:0]        frm_data_i,
  input  logic [TS_W-1:0]   timer_i,
  input  logic              rss_en_i,
  input  logic [3:0]        rss_type_i,
  input  logic              is_ipv4_i,
  input  logic              is_ipv6_i,
  input  logic [1:0]        l4_kind_i,
  output logic              ts_valid_o,
  output logic [HALF_W-1:0] stamp_lo_o,
  output logic [HALF_W-1:0] stamp_hi_o,
  output logic [31:0]       src_id_o,
  output logic [31:0]       src_seq_o,
  output logic              done_o,
  output logic [IDX_W-1:0]  filt_idx_o,
  output logic [15:0]       pkt_type_o,
  output logic [31:0]       stat_o
);
  localparam int SEL_W = $clog2(N_FILT);
  localparam logic [IDX_W-1:0] NO_HIT = IDX_W'(N_FILT);

  filt_t                 filt [N_FILT];
  logic [7:0]            msg_cfg;
  logic                  glob_en;
  logic                  sof_beat, eof_beat, at_et, at_last;
  logic [FB_ETYPE_W-1:0] etype;
  ptp_fld_t              fld;
  logic                  c_hit, c_ts;
  logic [IDX_W-1:0]      c_idx;

  rx_stamp_regs #(.N_FILT(N_FILT), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .filt_o    (filt),
    .msg_o     (msg_cfg),
    .glob_en_o (glob_en)
  );

  rx_stamp_parse #(.CNT_W(CNT_W)) u_parse (
    .clk_i, .rst_ni,
    .vld_i      (frm_vld_i),
    .sof_i      (frm_sof_i),
    .eof_i      (frm_eof_i),
    .data_i     (frm_data_i),
    .sof_beat_o (sof_beat),
    .eof_beat_o (eof_beat),
    .at_et_o    (at_et),
    .at_last_o  (at_last),
    .etype_o    (etype),
    .fld_o      (fld)
  );

  rx_stamp_match #(.N_FILT(N_FILT), .IDX_W(IDX_W)) u_match (
    .filt_i  (filt),
    .etype_i (etype),
    .hit_o   (c_hit),
    .idx_o   (c_idx),
    .ts_o    (c_ts)
  );

  // per-frame match state, loaded on the EtherType low-byte beat
  logic             hit_q, ts_q, took_q;
  logic [IDX_W-1:0] idx_q;
  logic             eff_hit, eff_ts, eff_took, take;
  logic [IDX_W-1:0] eff_idx;

  always_comb begin
    if (at_et) begin
      eff_hit = c_hit;
      eff_idx = c_idx;
      eff_ts  = c_ts;
    end else if (sof_beat) begin
      eff_hit = 1'b0;
      eff_idx = NO_HIT;
      eff_ts  = 1'b0;
    end else begin
      eff_hit = hit_q;
      eff_idx = idx_q;
      eff_ts  = ts_q;
    end
  end

  assign take = at_last && eff_hit && eff_ts && glob_en && !ts_valid_o &&
                (fld.ver == 4'd2) && (fld.msg == msg_cfg);
  assign eff_took = take || (took_q && !sof_beat);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      ts_q   <= 1'b0;
      idx_q  <= NO_HIT;
      took_q <= 1'b0;
    end else if (frm_vld_i) begin
      hit_q  <= eff_hit;
      ts_q   <= eff_ts;
      idx_q  <= eff_idx;
      took_q <= eff_took;
    end
  end

  // capture registers; capture outranks a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_valid_o <= 1'b0;
    end else if (take) begin
      ts_valid_o <= 1'b1;
    end else if (ts_clr_i) begin
      ts_valid_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stamp_lo_o <= '0;
      stamp_hi_o <= '0;
      src_id_o   <= '0;
      src_seq_o  <= '0;
    end else if (take) begin
      stamp_lo_o <= timer_i[HALF_W-1:0];
      stamp_hi_o <= timer_i[TS_W-1:HALF_W];
      src_id_o   <= fld.id[31:0];
      src_seq_o  <= {frm_data_i, fld.seq_lo, fld.id[47:32]};
    end
  end

  // metadata
  logic [15:0] rss_term, pt_d;

  assign rss_term = rss_en_i ? {12'd0, rss_type_i} : 16'd0;

  always_comb begin
    pt_d = rss_term;
    if (eff_hit) begin
      pt_d[PT_HIT] = 1'b1;
      pt_d[PT_IDX +: SEL_W] = eff_idx[SEL_W-1:0];
    end else begin
      pt_d[PT_IPV4] = is_ipv4_i;
      pt_d[PT_IPV6] = is_ipv6_i;
      unique case (l4_kind_e'(l4_kind_i))
        L4_TCP:  pt_d[PT_TCP]  = 1'b1;
        L4_UDP:  pt_d[PT_UDP]  = 1'b1;
        L4_SCTP: pt_d[PT_SCTP] = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      filt_idx_o <= NO_HIT;
      pkt_type_o <= '0;
      stat_o     <= '0;
    end else begin
      done_o <= eof_beat;
      if (eof_beat) begin
        filt_idx_o    <= eff_idx;
        pkt_type_o    <= pt_d;
        stat_o        <= '0;
        stat_o[ST_TS] <= eff_took;
      end
    end
  end
endmodule

// File: rtl/rx_etype_stamp_chk.sv
module rx_etype_stamp_chk
  import rx_stamp_pkg::*;
#(
  parameter int  N_FILT = 8,
  parameter int  TS_W   = 64,
  parameter int  CNT_W  = 6,
  localparam int IDX_W  = $clog2(N_FILT + 1),
  localparam int ADDR_W = $clog2(N_FILT + 2),
  localparam int HALF_W = TS_W / 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic              ts_clr_i,
  input logic              frm_vld_i,
  input logic              frm_sof_i,
  input logic              frm_eof_i,
  input logic [7:0]        frm_data_i,
  input logic [TS_W-1:0]   timer_i,
  input logic              rss_en_i,
  input logic [3:0]        rss_type_i,
  input logic              is_ipv4_i,
  input logic              is_ipv6_i,
  input logic [1:0]        l4_kind_i,
  input logic              ts_valid_o,
  input logic [HALF_W-1:0] stamp_lo_o,
  input logic [HALF_W-1:0] stamp_hi_o,
  input logic [31:0]       src_id_o,
  input logic [31:0]       src_seq_o,
  input logic              done_o,
  input logic [IDX_W-1:0]  filt_idx_o,
  input logic [15:0]       pkt_type_o,
  input logic [31:0]       stat_o
);
  localparam int SEL_W = $clog2(N_FILT);

  a_r5_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_valid_o && !ts_clr_i |=> ts_valid_o);

  a_r5_capture_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_valid_o |=> $stable(stamp_lo_o) && $stable(stamp_hi_o) &&
                   $stable(src_id_o) && $stable(src_seq_o));

  a_r9_flag_implies_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && stat_o[ST_TS] |-> ts_valid_o);

  a_r7_hit_format: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && pkt_type_o[PT_HIT] |->
      pkt_type_o[PT_IDX +: SEL_W] == filt_idx_o[SEL_W-1:0] &&
      pkt_type_o[10:8] == 3'b000);

  a_r8_l4_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !pkt_type_o[PT_HIT] |-> $onehot0(pkt_type_o[10:8]));

  a_r1_idx_consistent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (filt_idx_o <= IDX_W'(N_FILT)) &&
               ((filt_idx_o == IDX_W'(N_FILT)) == !pkt_type_o[PT_HIT]));

  a_r10_done_after_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(frm_vld_i && frm_eof_i));
endmodule

bind rx_etype_stamp rx_etype_stamp_chk #(
  .N_FILT(N_FILT), .TS_W(TS_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/rx_etype_stamp_tb_top.sv
module rx_etype_stamp_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        ts_clr = 1'b0;
  logic        vld = 1'b0, sof = 1'b0, eof = 1'b0;
  logic [7:0]  data = '0;
  logic [63:0] tmr = 64'h0123_4567_0000_0000;
  logic        rss_en = 1'b0;
  logic [3:0]  rss_type = '0;
  logic        ipv4 = 1'b0, ipv6 = 1'b0;
  logic [1:0]  l4 = '0;
  logic        ts_valid, done;
  logic [31:0] stamp_lo, stamp_hi, src_id, src_seq, stat;
  logic [3:0]  filt_idx;
  logic [15:0] pkt_type;

  always #5 clk = ~clk;
  always @(posedge clk) tmr <= tmr + 64'h1_0000_0003;

  rx_etype_stamp dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .ts_clr_i(ts_clr),
    .frm_vld_i(vld), .frm_sof_i(sof), .frm_eof_i(eof), .frm_data_i(data),
    .timer_i(tmr),
    .rss_en_i(rss_en), .rss_type_i(rss_type), .is_ipv4_i(ipv4),
    .is_ipv6_i(ipv6), .l4_kind_i(l4),
    .ts_valid_o(ts_valid), .stamp_lo_o(stamp_lo), .stamp_hi_o(stamp_hi),
    .src_id_o(src_id), .src_seq_o(src_seq), .done_o(done),
    .filt_idx_o(filt_idx), .pkt_type_o(pkt_type), .stat_o(stat)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [31:0] m_filt [8];
  logic [7:0]  m_msg = '0;
  logic        m_en = 1'b0;
  logic        m_valid = 1'b0;
  logic [63:0] m_stamp = '0;
  logic [31:0] m_id = '0, m_seq = '0;
  logic [7:0]  frm [64];

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a < 8) m_filt[a] = d;
    else if (a == 8) m_msg = d[15:8];
    else if (a == 9) m_en = d[0];
  endtask

  task automatic clear_flag();
    @(negedge clk);
    ts_clr = 1'b1;
    @(posedge clk); #1;
    m_valid = 1'b0;
    chk("R5", "valid after clear", ts_valid, 0);
    @(negedge clk);
    ts_clr = 1'b0;
  endtask

  task automatic build(input int len, input logic [15:0] et,
                       input bit ver_ok, input bit msg_ok);
    for (int i = 0; i < 64; i++) frm[i] = 8'($urandom);
    frm[12] = et[15:8];
    frm[13] = et[7:0];
    frm[14] = msg_ok ? m_msg : (m_msg ^ 8'h5A);
    frm[15] = {4'($urandom), ver_ok ? 4'd2 : 4'd3};
    if (len < 0) frm[0] = 8'h00;
  endtask

  function automatic logic [15:0] exp_pt(input bit hit, input int idx);
    logic [15:0] p;
    p = rss_en ? {12'd0, rss_type} : 16'd0;
    if (hit) begin
      p[11] = 1'b1;
      p[6:4] = 3'(idx);
    end else begin
      p[4] = ipv4;
      p[6] = ipv6;
      if (l4 == 2'd1) p[8] = 1'b1;
      if (l4 == 2'd2) p[9] = 1'b1;
      if (l4 == 2'd3) p[10] = 1'b1;
    end
    return p;
  endfunction

  task automatic send(input int len, input bit clr_last, input bit bubbles);
    bit hit, qual;
    int idx;
    logic [15:0] et;
    hit = 1'b0; idx = 8;
    rss_en = 1'($urandom); rss_type = 4'($urandom);
    ipv4 = 1'($urandom); ipv6 = 1'($urandom); l4 = 2'($urandom);
    et = {frm[12], frm[13]};
    if (len >= 14)
      for (int k = 7; k >= 0; k--)
        if (m_filt[k][26] && m_filt[k][15:0] == et) begin hit = 1'b1; idx = k; end
    qual = hit && m_filt[idx][30] && m_en && !m_valid && len >= 46 &&
           frm[15][3:0] == 4'd2 && frm[14] == m_msg;
    for (int i = 0; i < len; i++) begin
      if (bubbles && i > 0 && ($urandom % 5) == 0) begin
        @(negedge clk);
        vld = 1'b0; sof = 1'b0; eof = 1'b0; ts_clr = 1'b0;
      end
      @(negedge clk);
      vld = 1'b1; sof = (i == 0); eof = (i == len - 1); data = frm[i];
      ts_clr = clr_last && (i == 45);
      if (i == 45) begin
        if (qual) begin
          m_valid = 1'b1;
          m_stamp = tmr;
          m_id  = {frm[39], frm[38], frm[37], frm[36]};
          m_seq = {frm[45], frm[44], frm[41], frm[40]};
        end else if (clr_last) begin
          m_valid = 1'b0;
        end
      end
    end
    @(posedge clk); #1;
    chk("R10", "done after eof", done, 1);
    chk("R1", "filter index", filt_idx, idx);
    chk(hit ? "R7" : "R8", "packet type", pkt_type, exp_pt(hit, idx));
    chk("R9", "status", stat, qual ? 32'h0001_0000 : 32'h0);
    chk(clr_last ? "R12" : "R5", "valid flag", ts_valid, m_valid);
    chk(qual ? "R5" : "R11", "stamp", {stamp_hi, stamp_lo}, m_stamp);
    chk(qual ? "R6" : "R11", "identity", {src_seq, src_id}, {m_seq, m_id});
    @(negedge clk);
    vld = 1'b0; sof = 1'b0; eof = 1'b0; ts_clr = 1'b0;
    @(posedge clk); #1;
    chk("R10", "done one cycle", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1588));
    for (int k = 0; k < 8; k++) m_filt[k] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R13", "reset valid", ts_valid, 0);
    chk("R13", "reset done", done, 0);
    chk("R13", "reset idx", filt_idx, 8);
    chk("R13", "reset stamp", {stamp_hi, stamp_lo}, 0);
    chk("R13", "reset ids", {src_seq, src_id}, 0);
    rst_n = 1'b1;

    wr(0, 32'h0400_1234);             // enabled, no timestamp
    wr(1, 32'hE407_88F7);             // R2 stray bits 31,29,18:16 set
    wr(2, 32'h4400_88F7);             // same type, lower priority
    wr(3, 32'h4000_0800);             // disabled
    wr(5, 32'h4400_ABCD);
    wr(8, 32'h0000_1000);
    wr(9, 32'h1);

    build(46, 16'h88F7, 1, 1); send(46, 0, 0);   // R1 R3 R5 R6 minimum length
    build(60, 16'h88F7, 1, 1); send(60, 0, 1);   // R5 blocked while valid
    clear_flag();
    build(45, 16'h88F7, 1, 1); send(45, 0, 0);   // R3 R11 one byte short
    build(60, 16'h88F7, 0, 1); send(60, 0, 0);   // R4 version
    build(60, 16'h88F7, 1, 0); send(60, 0, 0);   // R4 message byte
    build(60, 16'h0800, 1, 1); send(60, 0, 0);   // R2 R8 disabled filter
    build(60, 16'h1234, 1, 1); send(60, 0, 0);   // R3 no timestamp bit
    build(50, 16'hABCD, 1, 1); send(50, 1, 0);   // R12 clear with capture
    clear_flag();
    wr(9, 32'h0);
    build(60, 16'h88F7, 1, 1); send(60, 0, 0);   // R3 global disable
    wr(9, 32'h1);
    build(10, 16'h88F7, 1, 1); send(10, 0, 0);   // R11 runt frame
    build(1, 16'h88F7, 1, 1); send(1, 0, 0);     // R11 single byte

    for (int n = 0; n < 200; n++) begin
      int len;
      logic [15:0] et;
      case ($urandom % 6)
        0: len = 12; 1: len = 14; 2: len = 40;
        3: len = 45; 4: len = 46; default: len = 46 + int'($urandom % 18);
      endcase
      case ($urandom % 5)
        0: et = 16'h88F7; 1: et = 16'h1234; 2: et = 16'h0800;
        3: et = 16'hABCD; default: et = 16'($urandom);
      endcase
      build(len, et, ($urandom % 4) != 0, ($urandom % 4) != 0);
      send(len, ($urandom % 8) == 0, 1);
      if (($urandom % 3) == 0) clear_flag();
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule